// File: doc/BRIEF.md
# Vector Element Extract Unit

This unit executes one vector-to-scalar extract operation. It takes a 32-bit instruction word, a scalar operand value and the current element width, and produces one scalar result. The result is a single element read from a vector register. The instruction fields choose the source vector register, the register that supplies the index, and the scalar destination. The unit holds its own small vector register file. That file has a write port, so the surrounding logic (or a testbench) can fill it before any extract is issued.

The element index is the full unsigned value of the index register. When the index field names register zero, the index is fixed at 0 and the operation becomes a plain move of element 0. The count of legal elements is VLEN divided by the element width, and register grouping plays no part in it. An index at or past that count gives a zero result rather than wrapping. The chosen element is zero-extended to XLEN bits. It comes out one cycle after a start pulse, together with the destination index and a write enable. Writes to scalar register zero are blocked. Words that do not decode, and reserved width settings, raise an illegal flag instead of writing.

Top module: `vx_extract_unit`

## Requirements
- R1: A word decodes as the extract operation only when bits [31:26] = 001100, bit 25 = 1, bits [14:12] = 010 and bits [6:0] = 1010111. The source vector register is taken from bits [24:20], the index register from bits [19:15] and the destination from bits [11:7]. A decoded word with a nonzero destination gives rd_we = 1 and illegal = 0 in the result cycle.
- R2: If any one of the four decoded fields differs, the result cycle shows illegal = 1, rd_we = 0 and rd_data = 0.
- R3: The width code elem_width selects the element size: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. Codes 4 to 7 are reserved and give illegal = 1, rd_we = 0 and rd_data = 0.
- R4: When the index field (bits [19:15]) is zero, element 0 is returned whatever value is on idx_value.
- R5: Otherwise the index is the full unsigned idx_value. If it is greater than or equal to VLEN/width, rd_data is 0. This holds even when the low index bits alone would point to a valid element.
- R6: Element i starts at byte i*(width/8) of the register and is stored little-endian. The element is zero-extended to XLEN bits on rd_data.
- R7: A destination field of zero still gives done = 1 but keeps rd_we = 0.
- R8: The result (done, rd_idx, rd_data, rd_we, illegal) appears in the cycle after the edge that sees start = 1. Starts on back-to-back cycles each give their own result. With no start, done = 0 in the next cycle.
- R9: A write through vrf_we/vrf_sel/vrf_data replaces exactly one vector register. Later extracts see the new contents, and the other registers are unchanged.
- R10: During and right after reset, done, rd_we, illegal, rd_idx and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vrf_we | input | 1 | Vector register file write enable |
| vrf_sel | input | 5 | Vector register written |
| vrf_data | input | VLEN (128) | Data for the vector register write |
| start | input | 1 | Issue: latch word, index value and width |
| instr | input | 32 | Instruction word |
| idx_value | input | XLEN (64) | Value of the index scalar register |
| elem_width | input | 3 | Element width code |
| done | output | 1 | Result valid this cycle |
| illegal | output | 1 | Word or width not accepted |
| rd_we | output | 1 | Scalar register write enable |
| rd_idx | output | 5 | Scalar destination index |
| rd_data | output | XLEN (64) | Scalar write data |

## Verification
All outputs come from one stage of registers plus combinational logic. Every result is therefore due exactly one clock edge after the edge that samples start. The bench drives each issue on a falling edge and reads all outputs on the following falling edge, halfway through the result cycle. It then drops start and checks on the next falling edge that done has gone low again. Vector register writes take effect at the edge that samples them, so the bench always lets at least one edge pass between a write and the extract that reads it.

// File: rtl/vx_pkg.sv
package vx_pkg;
  localparam logic [5:0] F6_EXTRACT = 6'b001100;
  localparam logic [2:0] F3_MVX     = 3'b010;
  localparam logic [6:0] OP_VECTOR  = 7'b1010111;

  typedef struct packed {
    logic       match;
    logic [4:0] vsrc;
    logic [4:0] xidx;
    logic [4:0] xdst;
  } vx_fields_t;
endpackage

// File: rtl/vx_decode.sv
module vx_decode
  import vx_pkg::*;
(
  input  logic [31:0] word,
  input  logic [2:0]  width_code,
  output vx_fields_t  fld,
  output logic        bad
);
  always_comb begin
    fld.match = (word[31:26] == F6_EXTRACT) && word[25] &&
                (word[14:12] == F3_MVX) && (word[6:0] == OP_VECTOR);
    fld.vsrc  = word[24:20];
    fld.xidx  = word[19:15];
    fld.xdst  = word[11:7];
    // reserved width codes have the top bit set
    bad       = !fld.match || width_code[2];
  end
endmodule

// File: rtl/vx_vrf.sv
module vx_vrf #(
  parameter int VLEN  = 128,
  parameter int NREG  = 32,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [SELW-1:0] wsel,
  input  logic [VLEN-1:0] wdata,
  input  logic [SELW-1:0] rsel,
  output logic [VLEN-1:0] rdata
);
  logic [VLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[wsel] <= wdata;
  end

  assign rdata = regs[rsel];
endmodule

// File: rtl/vx_select.sv
module vx_select #(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  localparam int BYTES = VLEN / 8,
  localparam int LIDXW = $clog2(BYTES)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [XLEN-1:0] idx_raw,
  input  logic            src_zero,
  input  logic [1:0]      wsel,
  output logic [63:0]     elem,
  output logic            in_range
);
  // legal elements per register: VLEN/8 bytes divided by bytes per element
  function automatic logic [XLEN-1:0] elem_count(input logic [1:0] s);
    return XLEN'(BYTES) >> s;
  endfunction

  // little-endian slice: element li starts at byte li << s
  function automatic logic [63:0] slice(input logic [VLEN-1:0] v,
                                        input logic [LIDXW-1:0] li,
                                        input logic [1:0] s);
    logic [VLEN-1:0] sh;
    sh = v >> ((int'(li) << s) * 8);
    case (s)
      2'd0:    return {56'd0, sh[7:0]};
      2'd1:    return {48'd0, sh[15:0]};
      2'd2:    return {32'd0, sh[31:0]};
      default: return sh[63:0];
    endcase
  endfunction

  logic [XLEN-1:0]  eff_idx;
  logic [XLEN-1:0]  cnt;
  logic [LIDXW-1:0] lidx;

  always_comb begin
    eff_idx  = src_zero ? '0 : idx_raw;
    cnt      = elem_count(wsel);
    in_range = eff_idx < cnt;
    // storage address uses masked low bits only, so the read never leaves the register
    lidx     = eff_idx[LIDXW-1:0] & LIDXW'(cnt - 1'b1);
    elem     = in_range ? slice(vec, lidx, wsel) : 64'd0;
  end
endmodule

// File: rtl/vx_extract_unit.sv
module vx_extract_unit
  import vx_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vrf_we,
  input  logic [SELW-1:0] vrf_sel,
  input  logic [VLEN-1:0] vrf_data,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] idx_value,
  input  logic [2:0]      elem_width,
  output logic            done,
  output logic            illegal,
  output logic            rd_we,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_data
);
  logic [31:0]     q_instr;
  logic [XLEN-1:0] q_idx;
  logic [2:0]      q_width;
  logic            q_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_instr <= '0;
      q_idx   <= '0;
      q_width <= '0;
      q_done  <= 1'b0;
    end else begin
      q_done <= start;
      if (start) begin
        q_instr <= instr;
        q_idx   <= idx_value;
        q_width <= elem_width;
      end
    end
  end

  vx_fields_t fld;
  logic       dec_bad;

  vx_decode u_dec (
    .word       (q_instr),
    .width_code (q_width),
    .fld        (fld),
    .bad        (dec_bad)
  );

  logic [VLEN-1:0] vreg_rd;

  vx_vrf #(.VLEN(VLEN), .NREG(NREG)) u_vrf (
    .clk   (clk),
    .we    (vrf_we),
    .wsel  (vrf_sel),
    .wdata (vrf_data),
    .rsel  (SELW'(fld.vsrc)),
    .rdata (vreg_rd)
  );

  logic [63:0] sel_elem;
  logic        sel_in_range;

  vx_select #(.VLEN(VLEN), .XLEN(XLEN)) u_sel (
    .vec      (vreg_rd),
    .idx_raw  (q_idx),
    .src_zero (fld.xidx == 5'd0),
    .wsel     (q_width[1:0]),
    .elem     (sel_elem),
    .in_range (sel_in_range)
  );

  // named result events for the checks below
  logic res_ok;
  assign res_ok  = q_done && !dec_bad;

  assign done    = q_done;
  assign illegal = q_done && dec_bad;
  assign rd_we   = res_ok && (fld.xdst != 5'd0);
  assign rd_idx  = q_done ? fld.xdst : 5'd0;
  assign rd_data = res_ok ? XLEN'(sel_elem) : '0;

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r8_idle_after_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r2_illegal_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rd_we && rd_data == '0));
  a_r7_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_idx != 5'd0));
  a_r5_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sel_in_range) |-> (rd_data == '0));
  a_r6_byte_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ok && q_width == 3'd0) |-> (rd_data[XLEN-1:8] == '0));
  a_r4_src0_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ok && fld.xidx == 5'd0) |-> sel_in_range);
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!rd_we && !illegal && rd_data == '0));
endmodule

// File: tb/sim_vx_extract_unit.sv
module sim_vx_extract_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN = 128;
  localparam int XLEN = 64;
  localparam int NB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            vrf_we = 1'b0;
  logic [4:0]      vrf_sel = '0;
  logic [VLEN-1:0] vrf_data = '0;
  logic            start = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] idx_value = '0;
  logic [2:0]      elem_width = '0;
  logic            done, illegal, rd_we;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [32][NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  vx_extract_unit u0 (
    .clk(clk), .rst_n(rst_n), .vrf_we(vrf_we), .vrf_sel(vrf_sel), .vrf_data(vrf_data),
    .start(start), .instr(instr), .idx_value(idx_value), .elem_width(elem_width),
    .done(done), .illegal(illegal), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm, input logic [4:0] vs,
                                     input logic [4:0] xs, input logic [2:0] f3,
                                     input logic [4:0] xd, input logic [6:0] op);
    return {f6, vm, vs, xs, f3, xd, op};
  endfunction

  function automatic logic [31:0] good(input logic [4:0] vs, input logic [4:0] xs, input logic [4:0] xd);
    return mk(6'b001100, 1'b1, vs, xs, 3'b010, xd, 7'b1010111);
  endfunction

  // independent reference: bytes gathered one at a time from the shadow copy
  function automatic logic [63:0] model(input int r, input int w, input logic [63:0] idx, input bit src0);
    int n = 1 << w;
    int cnt = NB / n;
    logic [63:0] i = src0 ? 64'd0 : idx;
    logic [63:0] res = 64'd0;
    if (i >= 64'(cnt)) return 64'd0;
    for (int k = 0; k < n; k++) res |= 64'(shadow[r][int'(i) * n + k]) << (8 * k);
    return res;
  endfunction

  task automatic vwrite(input int r, input logic [VLEN-1:0] v);
    @(negedge clk);
    vrf_we = 1'b1; vrf_sel = 5'(r); vrf_data = v;
    for (int b = 0; b < NB; b++) shadow[r][b] = v[b*8 +: 8];
    @(negedge clk);
    vrf_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] v, input logic [2:0] s);
    @(negedge clk);
    instr = w; idx_value = v; elem_width = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk(done == 0 && rd_we == 0 && illegal == 0, "R10 flags", {61'd0, done, rd_we, illegal}, 0);
    chk(rd_data == 0 && rd_idx == 0, "R10 data", rd_data | 64'(rd_idx), 0);
  endtask

  task automatic t_preload();
    for (int r = 0; r < 32; r++) begin
      logic [VLEN-1:0] v;
      for (int b = 0; b < NB; b++) v[b*8 +: 8] = 8'(r * 37 + b * 11 + 5);
      vwrite(r, v);
    end
  endtask

  task automatic t_sweep();
    int regs [3] = '{1, 7, 31};
    foreach (regs[q]) begin
      for (int w = 0; w < 4; w++) begin
        for (int i = 0; i < (NB >> w); i++) begin
          issue(good(5'(regs[q]), 5'd3, 5'd9), 64'(i), 3'(w));
          chk(rd_data == model(regs[q], w, 64'(i), 0), "R6 element value", rd_data, model(regs[q], w, 64'(i), 0));
        end
      end
    end
    issue(good(5'd4, 5'd3, 5'd12), 64'd1, 3'd1);
    chk(done && rd_we && !illegal && rd_idx == 5'd12, "R1 legal write",
        {55'd0, done, rd_we, illegal, rd_idx}, {55'd0, 1'b1, 1'b1, 1'b0, 5'd12});
  endtask

  task automatic t_range();
    logic [63:0] idxs [4] = '{64'd16, 64'h1_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, 64'd17};
    foreach (idxs[q]) begin
      issue(good(5'd5, 5'd2, 5'd8), idxs[q], 3'd0);
      chk(rd_data == 0 && rd_we, "R5 out of range byte", rd_data, 0);
    end
    issue(good(5'd5, 5'd2, 5'd8), 64'd2, 3'd3);
    chk(rd_data == 0, "R5 out of range 64-bit", rd_data, 0);
    issue(good(5'd5, 5'd2, 5'd8), 64'd1, 3'd3);
    chk(rd_data == model(5, 3, 64'd1, 0), "R5 last in range", rd_data, model(5, 3, 64'd1, 0));
  endtask

  task automatic t_src0();
    for (int w = 0; w < 4; w++) begin
      issue(good(5'd6, 5'd0, 5'd1), 64'hFFFF_0000_0000_0009, 3'(w));
      chk(rd_data == model(6, w, 64'd0, 1), "R4 element zero", rd_data, model(6, w, 64'd0, 1));
    end
  endtask

  task automatic t_rd0();
    issue(good(5'd2, 5'd1, 5'd0), 64'd0, 3'd2);
    chk(done && !rd_we && !illegal, "R7 x0 write blocked", {62'd0, done, rd_we}, 64'd2);
  endtask

  task automatic t_illegal();
    logic [31:0] ws [4] = '{mk(6'b001101, 1'b1, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1010111),
                            mk(6'b001100, 1'b0, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1010111),
                            mk(6'b001100, 1'b1, 5'd2, 5'd1, 3'b110, 5'd3, 7'b1010111),
                            mk(6'b001100, 1'b1, 5'd2, 5'd1, 3'b010, 5'd3, 7'b0010111)};
    foreach (ws[q]) begin
      issue(ws[q], 64'd0, 3'd0);
      chk(done && illegal && !rd_we && rd_data == 0, "R2 bad field",
          {61'd0, done, illegal, rd_we}, 64'd6);
    end
    for (int s = 4; s < 8; s++) begin
      issue(good(5'd2, 5'd1, 5'd3), 64'd0, 3'(s));
      chk(done && illegal && !rd_we && rd_data == 0, "R3 reserved width",
          {61'd0, done, illegal, rd_we}, 64'd6);
    end
  endtask

  task automatic t_handshake();
    @(negedge clk);
    instr = good(5'd9, 5'd1, 5'd4); idx_value = 64'd3; elem_width = 3'd0; start = 1'b1;
    @(negedge clk);
    chk(done && rd_idx == 5'd4 && rd_data == model(9, 0, 64'd3, 0), "R8 first result", rd_data, model(9, 0, 64'd3, 0));
    instr = good(5'd10, 5'd1, 5'd11); idx_value = 64'd1; elem_width = 3'd2;
    @(negedge clk);
    chk(done && rd_idx == 5'd11 && rd_data == model(10, 2, 64'd1, 0), "R8 back-to-back", rd_data, model(10, 2, 64'd1, 0));
    start = 1'b0;
    @(negedge clk);
    chk(!done && !rd_we, "R8 done drops", {62'd0, done, rd_we}, 0);
  endtask

  task automatic t_vrf();
    logic [VLEN-1:0] v = {64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_F00D_CAFE};
    vwrite(7, v);
    issue(good(5'd7, 5'd1, 5'd2), 64'd0, 3'd3);
    chk(rd_data == 64'h89AB_CDEF_F00D_CAFE, "R9 new contents", rd_data, 64'h89AB_CDEF_F00D_CAFE);
    issue(good(5'd8, 5'd1, 5'd2), 64'd1, 3'd3);
    chk(rd_data == model(8, 3, 64'd1, 0), "R9 neighbour kept", rd_data, model(8, 3, 64'd1, 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preload();
    t_sweep();
    t_range();
    t_src0();
    t_rd0();
    t_illegal();
    t_handshake();
    t_vrf();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule